// File: doc/BRIEF.md
# Interleaved Nibble Playback Selector

This block sits behind a flux-timing decoder that turns a spinning track into a stream of 4-bit nibbles. The track holds audio samples spread out with an interleave of five: within one rotation, only one nibble out of every five belongs to the sample sequence being played. The block counts the nibbles of each rotation from the index pulse onward. It passes on only those whose slot in the group of five matches the current rotation's phase, and holds each chosen value on its sample output until the next chosen one arrives. Each index pulse moves the phase on by one. Five rotations therefore play five shifted subsequences that together form one continuous stream, and nothing is buffered in memory.

The nibble input is a valid-only stream with no back-pressure. The decoder runs in step with the medium and cannot stall, so every cycle with the valid strobe high is consumed at once. The output side is a one-cycle hold strobe with the sample beside it. There is no ready signal on either side, and a downstream consumer that misses a strobe still sees the held value. A synchronous start input begins a new playback. It should be raised together with the index pulse of the first rotation.

Top module: `interleave_playback`

## Requirements
- R1: After reset, `sample_o` is midscale (8, i.e. only the most significant bit of the 4-bit value set), `hold_o` is 0, the phase is 0 and the position count is 0.
- R2: Every cycle with `nib_valid_i` high consumes one nibble and gives it a position. Positions count 0,1,2,3,4,0,... from the most recent index pulse.
- R3: Each index pulse without start advances the phase by one, wrapping from 4 back to 0. Start sets the phase to 0 and takes priority over a simultaneous index pulse.
- R4: A valid nibble whose position equals the phase raises `hold_o` for exactly the following cycle, and in that cycle `sample_o` equals that nibble.
- R5: `sample_o` changes only in a cycle where `hold_o` is high or in the cycle after start. Otherwise it holds its value.
- R6: Nibbles at unselected positions have no effect: no strobe, and `sample_o` is unchanged. `hold_o` is never high in the cycle after one without a valid nibble.
- R7: A nibble that arrives in the same cycle as the index pulse is position 0 of the new rotation and is compared against the already advanced phase.
- R8: Start clears `sample_o` to midscale in the next cycle. A nibble valid in the same cycle as start is position 0 under phase 0, so it is selected and replaces the midscale value.
- R9: The input takes no back-pressure, and `hold_o` is a one-cycle strobe with no ready. Back-to-back valid cycles are all counted.
- R10: With 12 nibbles per rotation, rotations 1 to 5 after start play positions {0,5,10}, {1,6,11}, {2,7}, {3,8}, {4,9}, and rotation 6 plays {0,5,10} again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin playback: phase and position to 0, sample to midscale |
| index_i | input | 1 | Once-per-rotation index pulse |
| nib_valid_i | input | 1 | Decoded nibble present this cycle |
| nib_data_i | input | NIB_W | Decoded nibble value |
| hold_o | output | 1 | One-cycle strobe: a new sample is on `sample_o` |
| sample_o | output | NIB_W | Held sample value |

## Verification
The assertions check on every cycle that the held sample never moves without a strobe or a start. They also check that a strobe only ever follows a valid nibble and carries exactly that nibble, and that start alone returns the output to midscale while start with a nibble selects it. Which nibbles are chosen depends on the phase and position state, and that state is visible only through the order of the output. So the phase wrap after five index pulses, the coincident index-and-nibble case and the full interleaved play order are shown only by the bench's reference model and its multi-rotation scenarios.

// File: rtl/playback_pkg.sv
package playback_pkg;
  localparam int unsigned DEF_NIB_W  = 4;
  localparam int unsigned DEF_FACTOR = 5;

  function automatic int unsigned cnt_bits(input int unsigned modulus);
    return (modulus < 2) ? 1 : $clog2(modulus);
  endfunction
endpackage

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int unsigned MOD      = 5,
  parameter int unsigned CW       = 3,
  parameter bit          USE_NEXT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] val_o
);
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] q, cur, nxt, inc;

  assign cur = clr ? '0 : q;

  generate
    if ((1 << CW) == MOD) begin : g_pow2
      assign inc = cur + 1'b1;
    end else begin : g_cmp
      assign inc = (cur == LAST) ? '0 : cur + 1'b1;
    end
  endgenerate

  assign nxt = step ? inc : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  generate
    if (USE_NEXT) begin : g_next
      assign val_o = nxt;
    end else begin : g_cur
      assign val_o = cur;
    end
  endgenerate
endmodule

// File: rtl/sample_hold.sv
module sample_hold #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [NIB_W-1:0] din,
  output logic             hold_o,
  output logic [NIB_W-1:0] sample_o
);
  localparam logic [NIB_W-1:0] MID = NIB_W'(1 << (NIB_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o   <= 1'b0;
      sample_o <= MID;
    end else begin
      hold_o <= load;
      if (load)       sample_o <= din;
      else if (clear) sample_o <= MID;
    end
  end
endmodule

// File: rtl/interleave_playback.sv
module interleave_playback
  import playback_pkg::*;
#(
  parameter int unsigned NIB_W  = DEF_NIB_W,
  parameter int unsigned FACTOR = DEF_FACTOR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             index_i,
  input  logic             nib_valid_i,
  input  logic [NIB_W-1:0] nib_data_i,
  output logic             hold_o,
  output logic [NIB_W-1:0] sample_o
);
  localparam int unsigned CW = cnt_bits(FACTOR);

  logic [CW-1:0] slot;
  logic [CW-1:0] phase;
  logic          pick;

  // Position within the group of FACTOR, restarted by index or start.
  wrap_counter #(.MOD(FACTOR), .CW(CW), .USE_NEXT(1'b0)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (index_i | start_i),
    .step  (nib_valid_i),
    .val_o (slot)
  );

  // Rotation phase; the advanced value is used in the index cycle itself.
  wrap_counter #(.MOD(FACTOR), .CW(CW), .USE_NEXT(1'b1)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_i),
    .step  (index_i & ~start_i),
    .val_o (phase)
  );

  assign pick = nib_valid_i && (slot == phase);

  sample_hold #(.NIB_W(NIB_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_i),
    .load     (pick),
    .din      (nib_data_i),
    .hold_o   (hold_o),
    .sample_o (sample_o)
  );
endmodule

// File: rtl/playback_checks.sv
module playback_checks #(
  parameter int unsigned NIB_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             nib_valid_i,
  input logic [NIB_W-1:0] nib_data_i,
  input logic             hold_o,
  input logic [NIB_W-1:0] sample_o
);
  localparam logic [NIB_W-1:0] MID = NIB_W'(1 << (NIB_W - 1));

  p_sample_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (hold_o || $stable(sample_o)));

  p_no_strobe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_valid_i |=> !hold_o);

  p_strobe_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid_i |=> (!hold_o || sample_o == $past(nib_data_i)));

  p_start_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !nib_valid_i) |=> (!hold_o && sample_o == MID));

  p_start_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && nib_valid_i) |=> (hold_o && sample_o == $past(nib_data_i)));
endmodule

bind interleave_playback playback_checks #(.NIB_W(NIB_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .nib_valid_i (nib_valid_i),
  .nib_data_i  (nib_data_i),
  .hold_o      (hold_o),
  .sample_o    (sample_o)
);

// File: tb/test_interleave_playback.sv
`timescale 1ns/1ps
module test_interleave_playback;
  localparam int W = 4;
  localparam int F = 5;
  localparam int MIDV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, index_i = 1'b0, nib_valid_i = 1'b0;
  logic [W-1:0] nib_data_i = '0;
  logic hold_o;
  logic [W-1:0] sample_o;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  int m_pos = 0, m_ph = 0, m_samp = MIDV;
  bit m_hold = 1'b0;
  int played[$];

  always #2.5 clk = ~clk;

  interleave_playback #(.NIB_W(W), .FACTOR(F)) i_interleave_playback (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .index_i(index_i),
    .nib_valid_i(nib_valid_i), .nib_data_i(nib_data_i),
    .hold_o(hold_o), .sample_o(sample_o)
  );

  // Behavioural reference: rules of R2, R3, R4, R7, R8 applied per clock.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_ph = 0; m_samp = MIDV; m_hold = 1'b0;
    end else begin
      int ph_now, pos_now;
      if (start_i)      ph_now = 0;
      else if (index_i) ph_now = (m_ph + 1) % F;
      else              ph_now = m_ph;
      pos_now = (start_i || index_i) ? 0 : m_pos;
      m_hold = 1'b0;
      if (start_i) m_samp = MIDV;
      if (nib_valid_i) begin
        if (pos_now == ph_now) begin
          m_hold = 1'b1;
          m_samp = int'(nib_data_i);
        end
        pos_now = (pos_now + 1) % F;
      end
      m_pos = pos_now;
      m_ph  = ph_now;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (hold_o !== m_hold || int'(sample_o) != m_samp) begin
        fails++;
        $display("FAIL %s: hold=%0b sample=%0d expected hold=%0b sample=%0d",
                 cur_req, hold_o, sample_o, m_hold, m_samp);
      end
      if (hold_o === 1'b1) played.push_back(int'(sample_o));
    end
  end

  task automatic drive(input bit st, input bit ix, input bit v, input int d);
    @(posedge clk); #1;
    start_i = st; index_i = ix; nib_valid_i = v; nib_data_i = W'(d);
  endtask

  // One rotation of 12 nibbles, value = position mod 16; gaps via mask.
  task automatic rotation(input bit st, input bit idx_with_first, input int gap_mask);
    if (!idx_with_first) drive(st, 1'b1, 1'b0, 0);
    for (int p = 0; p < 12; p++) begin
      if (gap_mask[p % 8]) drive(1'b0, 1'b0, 1'b0, 0);
      if (p == 0 && idx_with_first) drive(st, 1'b1, 1'b1, p);
      else                          drive(1'b0, 1'b0, 1'b1, p);
    end
    drive(1'b0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (hold_o !== 1'b0 || int'(sample_o) != MIDV) begin
      fails++;
      $display("FAIL R1: hold=%0b sample=%0d expected hold=0 sample=%0d", hold_o, sample_o, MIDV);
    end

    // R10 R2 R3 R9: six rotations, back-to-back nibbles and gaps, separate index
    cur_req = "R10";
    played.delete();
    rotation(1'b1, 1'b0, 0);
    rotation(1'b0, 1'b0, 8'h05);
    cur_req = "R7";
    rotation(1'b0, 1'b1, 8'h00);
    rotation(1'b0, 1'b1, 8'h22);
    cur_req = "R9";
    rotation(1'b0, 1'b0, 0);
    cur_req = "R3";
    rotation(1'b0, 1'b0, 8'h81);
    repeat (2) drive(1'b0, 1'b0, 1'b0, 0);
    begin
      int exp_q[$];
      for (int r = 0; r < 6; r++)
        for (int p = r % F; p < 12; p += F) exp_q.push_back(p);
      checks++;
      if (played.size() != exp_q.size()) begin
        fails++;
        $display("FAIL R10: played %0d samples expected %0d", played.size(), exp_q.size());
      end else begin
        for (int i = 0; i < exp_q.size(); i++) begin
          checks++;
          if (played[i] != exp_q[i]) begin
            fails++;
            $display("FAIL R10: sample %0d = %0d expected %0d", i, played[i], exp_q[i]);
          end
        end
      end
    end

    // R6: unselected nibbles leave the held value alone
    cur_req = "R6";
    drive(1'b0, 1'b1, 1'b1, 3);
    drive(1'b0, 1'b0, 1'b1, 9);
    drive(1'b0, 1'b0, 1'b1, 14);
    drive(1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    checks++;
    if (int'(sample_o) != 9) begin
      fails++;
      $display("FAIL R6: sample=%0d expected 9", sample_o);
    end

    // R8: start alone returns to midscale; start with a nibble selects it
    cur_req = "R8";
    drive(1'b1, 1'b0, 1'b0, 0);
    drive(1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    checks++;
    if (int'(sample_o) != MIDV) begin
      fails++;
      $display("FAIL R8: sample=%0d expected %0d", sample_o, MIDV);
    end
    drive(1'b1, 1'b1, 1'b1, 13);
    drive(1'b0, 1'b0, 1'b1, 1);
    drive(1'b0, 1'b0, 1'b0, 0);
    @(negedge clk);
    checks++;
    if (int'(sample_o) != 13) begin
      fails++;
      $display("FAIL R8: sample=%0d expected 13", sample_o);
    end

    // R4 R5: mid-rotation start then a few index pulses with varied data
    cur_req = "R4";
    for (int k = 0; k < 40; k++) drive(k == 3, (k % 9) == 0, (k % 3) != 1, (k * 7) % 16);
    cur_req = "R5";
    repeat (4) drive(1'b0, 1'b0, 1'b0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule